// File: doc/BRIEF.md
# Extended-Precision Float to Signed Integer Converter

This unit turns an 80-bit extended-precision floating-point operand into a two's-complement signed integer. The destination is 16, 32 or 64 bits wide. It is the arithmetic core behind an integer store from a floating-point register. The operand is classified first. Its explicit-integer-bit significand is then aligned to the binary point and rounded under one of four rounding modes. The rounded magnitude is checked against the range of the chosen width, and the unit selects the result together with its status flags.

The unit reports three conditions. An invalid flag covers infinities, NaNs, unsupported encodings and out-of-range values. An inexact flag is raised whenever rounding discarded nonzero bits. A round-direction bit is set when the magnitude was increased. When an invalid condition meets an unmasked exception, the unit asserts a store-suppress output so the surrounding store path writes nothing. When the exception is masked, the unit delivers the "integer indefinite" pattern instead. The memory write, the register stack and instruction decoding belong to the surrounding datapath.

The conversion is combinational up to a single output register stage that loads when an input is presented, so every result appears one clock after its operand.

Top module: `ext2int_cvt`

## Requirements
- R1: A result and its flags appear on the outputs exactly one clock after `in_valid` is high, with `out_valid` high in that cycle. `out_valid` is low in any cycle that follows a cycle without `in_valid`. While reset is active, `out_valid`, `out_result` and every flag are 0.
- R2: `in_width` selects the destination: 00 = 16 bits, 01 = 32 bits, 10 and 11 = 64 bits. `out_result` holds the two's-complement result sign-extended to 64 bits.
- R3: `in_rc` selects the rounding of a non-integral value: 00 = nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero.
- R4: A finite nonzero magnitude below 1 converts to 0, +1 or -1, depending on the rounding mode and the sign.
- R5: Both +0 and -0 convert to 0 with every flag clear.
- R6: The operand carries the sign in bit 79, a biased exponent (bias 16383) in bits 78:64 and a significand in bits 63:0 with an explicit integer bit 63. An all-ones exponent (infinity or NaN) raises invalid. So does a nonzero, non-all-ones exponent with bit 63 clear, which is an unsupported encoding.
- R7: The range check applies to the rounded value. A result above 2^(N-1)-1 or below -2^(N-1) for width N raises invalid.
- R8: On invalid with `in_inv_mask` = 0, `out_suppress` is 1 and `out_result` is 0.
- R9: On invalid with `in_inv_mask` = 1, `out_suppress` is 0 and `out_result` is the most negative value of the chosen width, sign-extended: 0xFFFFFFFFFFFF8000, 0xFFFFFFFF80000000 or 0x8000000000000000.
- R10: `out_inexact` is 1 exactly when a valid result differs from the operand's value. An invalid result clears it.
- R11: `out_c1` is 1 when an inexact result's magnitude was rounded upward and 0 otherwise. It is always 0 without inexact.
- R12: An operand with a zero exponent and a nonzero significand is a finite value of magnitude below 1 and is rounded as such.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 80 | Extended-precision source value |
| in_width | input | 2 | Destination width select |
| in_rc | input | 2 | Rounding mode |
| in_inv_mask | input | 1 | 1 = invalid exception masked |
| out_valid | output | 1 | Result present |
| out_result | output | 64 | Signed result, sign-extended |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_c1 | output | 1 | Magnitude was rounded up |
| out_suppress | output | 1 | Do not store the result |

## Verification
The assertions watch the flag relationships on every cycle. Suppress never appears without invalid. The round-up bit never appears without inexact. Invalid excludes inexact. A masked invalid always yields a pattern with only the sign bits set. Narrow results are always correctly sign-extended. One-cycle validity is also checked on every cycle. Whether a value is rounded the right way, whether the range boundary falls exactly at -2^(N-1) and 2^(N-1)-1, and how each operand class is recognised can only be shown by the bench's directed operands with precomputed results.

// File: rtl/e2i_pkg.sv
package e2i_pkg;
  parameter int EXP_W = 15;
  parameter int SIG_W = 64;
  parameter int OP_W  = 1 + EXP_W + SIG_W;
  parameter int INT_W = 64;
  parameter int UEW   = EXP_W + 2;
  parameter int SHW   = $clog2(SIG_W + 2);
  parameter int NUM_W = 3;
  parameter int MIN_W = 16;
  parameter int WSW   = 2;

  typedef enum logic [1:0] {
    RC_NEAR = 2'b00,
    RC_DOWN = 2'b01,
    RC_UP   = 2'b10,
    RC_ZERO = 2'b11
  } rc_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_DENORM,
    CL_NORMAL,
    CL_INF,
    CL_NAN,
    CL_UNSUP
  } cls_e;

  typedef struct packed {
    logic                  sign;
    cls_e                  cls;
    logic signed [UEW-1:0] uexp;
  } opinfo_t;
endpackage

// File: rtl/e2i_classify.sv
module e2i_classify
  import e2i_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  output opinfo_t          info,
  output logic [SIG_W-1:0] sig
);
  localparam logic signed [UEW-1:0] BIAS_V = UEW'((1 << (EXP_W - 1)) - 1);

  logic [EXP_W-1:0] bexp;
  logic             ibit;
  logic             frac_nz;

  assign bexp    = op[OP_W-2:SIG_W];
  assign sig     = op[SIG_W-1:0];
  assign ibit    = op[SIG_W-1];
  assign frac_nz = |op[SIG_W-2:0];

  always_comb begin
    info.sign = op[OP_W-1];
    info.uexp = $signed({2'b00, bexp}) - BIAS_V;
    if (bexp == '0) begin
      info.cls = (sig == '0) ? CL_ZERO : CL_DENORM;
    end else if (bexp == '1) begin
      if (!ibit)        info.cls = CL_UNSUP;
      else if (frac_nz) info.cls = CL_NAN;
      else              info.cls = CL_INF;
    end else begin
      info.cls = ibit ? CL_NORMAL : CL_UNSUP;
    end
  end
endmodule

// File: rtl/e2i_align_round.sv
module e2i_align_round
  import e2i_pkg::*;
(
  input  logic                  sign,
  input  logic                  is_normal,
  input  logic signed [UEW-1:0] uexp,
  input  logic [SIG_W-1:0]      sig,
  input  logic [1:0]            rc,
  output logic [SIG_W:0]        mag,
  output logic                  big,
  output logic                  inexact,
  output logic                  round_up
);
  localparam int WIDE = 2 * SIG_W + 2;
  localparam logic signed [UEW-1:0] UE_TOP  = UEW'(SIG_W);
  localparam logic signed [UEW-1:0] UE_MSB  = UEW'(SIG_W - 1);
  localparam logic signed [UEW-1:0] UE_NEG1 = '1;
  localparam logic [SHW-1:0]        SH_MAX  = SHW'(SIG_W + 1);

  logic [SHW-1:0]    shamt;
  logic [WIDE-1:0]   wide;
  logic [SIG_W-1:0]  ipart;
  logic              guard;
  logic              sticky;
  logic              inc;

  // shift distance from the explicit integer bit down to the binary point
  always_comb begin
    big   = 1'b0;
    shamt = SH_MAX;
    if (is_normal) begin
      if (uexp >= UE_TOP) begin
        big   = 1'b1;
        shamt = '0;
      end else if (uexp >= UE_NEG1) begin
        shamt = SHW'(UE_MSB - uexp);
      end
    end
  end

  assign wide   = {sig, {(SIG_W + 2){1'b0}}} >> shamt;
  assign ipart  = wide[WIDE-1 -: SIG_W];
  assign guard  = wide[SIG_W+1];
  assign sticky = |wide[SIG_W:0];

  always_comb begin
    inexact = guard | sticky;
    case (rc_e'(rc))
      RC_NEAR: inc = guard & (sticky | ipart[0]);
      RC_DOWN: inc = sign & inexact;
      RC_UP:   inc = ~sign & inexact;
      default: inc = 1'b0;
    endcase
    round_up = inc;
    mag      = {1'b0, ipart} + {{SIG_W{1'b0}}, inc};
  end
endmodule

// File: rtl/e2i_range_select.sv
module e2i_range_select
  import e2i_pkg::*;
(
  input  opinfo_t          info,
  input  logic [SIG_W:0]   mag,
  input  logic             big,
  input  logic             inexact,
  input  logic             round_up,
  input  logic [WSW-1:0]   width,
  input  logic             inv_mask,
  output logic [INT_W-1:0] result,
  output logic             invalid,
  output logic             inexact_o,
  output logic             c1,
  output logic             suppress
);
  logic [NUM_W-1:0] fit_v;
  logic [INT_W-1:0] indef_v [NUM_W];
  logic [WSW-1:0]   widx;
  logic             bad_cls;
  logic [INT_W-1:0] sval;

  // one range check and one indefinite pattern per destination width
  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int NB = MIN_W << g;
    localparam int HW = SIG_W - NB + 2;
    logic [HW-1:0] hi;
    assign hi         = mag[SIG_W:NB-1];
    assign fit_v[g]   = (hi == '0) ||
                        (info.sign && (hi == HW'(1)) && (mag[NB-2:0] == '0));
    assign indef_v[g] = {INT_W{1'b1}} << (NB - 1);
  end

  assign widx    = (width > WSW'(NUM_W - 1)) ? WSW'(NUM_W - 1) : width;
  assign bad_cls = (info.cls == CL_INF) || (info.cls == CL_NAN) ||
                   (info.cls == CL_UNSUP);
  assign sval    = info.sign ? (~mag[INT_W-1:0] + INT_W'(1)) : mag[INT_W-1:0];

  always_comb begin
    invalid   = bad_cls | big | ~fit_v[widx];
    suppress  = invalid & ~inv_mask;
    inexact_o = inexact & ~invalid;
    c1        = round_up & ~invalid;
    if (!invalid)      result = sval;
    else if (inv_mask) result = indef_v[widx];
    else               result = '0;
  end
endmodule

// File: rtl/ext2int_cvt.sv
module ext2int_cvt
  import e2i_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [79:0] in_operand,
  input  logic [1:0]  in_width,
  input  logic [1:0]  in_rc,
  input  logic        in_inv_mask,
  output logic        out_valid,
  output logic [63:0] out_result,
  output logic        out_invalid,
  output logic        out_inexact,
  output logic        out_c1,
  output logic        out_suppress
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  opinfo_t          info;
  logic [SIG_W-1:0] sig;
  logic [SIG_W:0]   mag;
  logic             big, inx, rup;
  logic [INT_W-1:0] res_c;
  logic             inv_c, inx_c, c1_c, sup_c;

  e2i_classify u_cls (
    .op   (in_operand),
    .info (info),
    .sig  (sig)
  );

  e2i_align_round u_rnd (
    .sign      (info.sign),
    .is_normal (info.cls == CL_NORMAL),
    .uexp      (info.uexp),
    .sig       (sig),
    .rc        (in_rc),
    .mag       (mag),
    .big       (big),
    .inexact   (inx),
    .round_up  (rup)
  );

  e2i_range_select u_sel (
    .info      (info),
    .mag       (mag),
    .big       (big),
    .inexact   (inx),
    .round_up  (rup),
    .width     (in_width),
    .inv_mask  (in_inv_mask),
    .result    (res_c),
    .invalid   (inv_c),
    .inexact_o (inx_c),
    .c1        (c1_c),
    .suppress  (sup_c)
  );

  logic [INT_W-1:0] res_d;
  logic             inv_d, inx_d, c1_d, sup_d;

  // next-state: load on a presented operand, hold otherwise
  always_comb begin
    res_d = out_result;
    inv_d = out_invalid;
    inx_d = out_inexact;
    c1_d  = out_c1;
    sup_d = out_suppress;
    if (in_valid) begin
      res_d = res_c;
      inv_d = inv_c;
      inx_d = inx_c;
      c1_d  = c1_c;
      sup_d = sup_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_invalid  <= 1'b0;
      out_inexact  <= 1'b0;
      out_c1       <= 1'b0;
      out_suppress <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_result   <= res_d;
      out_invalid  <= inv_d;
      out_inexact  <= inx_d;
      out_c1       <= c1_d;
      out_suppress <= sup_d;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    in_valid |=> out_valid);

  assert_suppress_has_invalid_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && out_suppress) |-> (out_invalid && out_result == '0));

  assert_indefinite_shape_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && out_invalid && !out_suppress) |->
      (out_result[63] && out_result[14:0] == '0));

  assert_invalid_no_inexact_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && out_invalid) |-> !out_inexact);

  assert_c1_needs_inexact_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && out_c1) |-> out_inexact);

  assert_narrow_sign_ext_R2: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && !out_invalid && $past(in_width) == 2'b00) |->
      (out_result[63:15] == '0 || out_result[63:15] == '1));
endmodule

// File: tb/test_ext2int_cvt.sv
`timescale 1ns/1ps
module test_ext2int_cvt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [79:0] in_operand;
  logic [1:0]  in_width;
  logic [1:0]  in_rc;
  logic        in_inv_mask;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid, out_inexact, out_c1, out_suppress;

  always #2 clk = ~clk;

  ext2int_cvt i_ext2int_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_width(in_width), .in_rc(in_rc), .in_inv_mask(in_inv_mask),
    .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_c1(out_c1), .out_suppress(out_suppress)
  );

  typedef struct packed {
    logic [63:0] res;
    logic        inv, inx, c1, sup;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  localparam logic [63:0] IND16 = 64'hFFFF_FFFF_FFFF_8000;
  localparam logic [63:0] IND32 = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] IND64 = 64'h8000_0000_0000_0000;

  function automatic logic [79:0] x80(real r);
    logic [63:0] b;
    logic [14:0] e;
    b = $realtobits(r);
    if (b[62:0] == '0) return {b[63], 79'b0};
    e = 15'(b[62:52]) - 15'd1023 + 15'd16383;
    return {b[63], e, 1'b1, b[51:0], 11'b0};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(input string tag, input logic [79:0] op, input logic [1:0] w,
                       input logic [1:0] rc, input logic msk, input logic [63:0] res,
                       input logic inv, input logic inx, input logic c1, input logic sup);
    exp_t e;
    @(negedge clk);
    in_valid    = 1'b1;
    in_operand  = op;
    in_width    = w;
    in_rc       = rc;
    in_inv_mask = msk;
    e.res = res; e.inv = inv; e.inx = inx; e.c1 = c1; e.sup = sup;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare each produced result with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected out_valid", 64'(out_valid), 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " result"},  out_result,          e.res);
        check({t, " invalid"}, 64'(out_invalid),    64'(e.inv));
        check({t, " inexact"}, 64'(out_inexact),    64'(e.inx));
        check({t, " c1"},      64'(out_c1),         64'(e.c1));
        check({t, " suppress"},64'(out_suppress),   64'(e.sup));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_operand = '0;
    in_width = 2'b00; in_rc = 2'b00; in_inv_mask = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", 64'(out_valid), 64'd0);
    check("R1 reset result", out_result, 64'd0);
    check("R1 reset flags", 64'({out_invalid, out_inexact, out_c1, out_suppress}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // rounding modes (R3, R11)
    drive("R3 near tie even 2.5", x80(2.5),  2'b01, 2'b00, 1, 64'd2, 0, 1, 0, 0);
    drive("R3 near tie up 3.5",   x80(3.5),  2'b01, 2'b00, 1, 64'd4, 0, 1, 1, 0);
    drive("R3 zero 2.5",          x80(2.5),  2'b01, 2'b11, 1, 64'd2, 0, 1, 0, 0);
    drive("R11 down -2.5",        x80(-2.5), 2'b01, 2'b01, 1, 64'hFFFF_FFFF_FFFF_FFFD, 0, 1, 1, 0);
    drive("R11 up -2.5",          x80(-2.5), 2'b01, 2'b10, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, 0, 0);
    // below one (R4)
    drive("R4 up 0.3",            x80(0.3),  2'b00, 2'b10, 1, 64'd1, 0, 1, 1, 0);
    drive("R4 up -0.3",           x80(-0.3), 2'b00, 2'b10, 1, 64'd0, 0, 1, 0, 0);
    drive("R4 down -0.3",         x80(-0.3), 2'b00, 2'b01, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1, 0);
    drive("R4 near 0.5",          x80(0.5),  2'b00, 2'b00, 1, 64'd0, 0, 1, 0, 0);
    drive("R4 near 0.75",         x80(0.75), 2'b00, 2'b00, 1, 64'd1, 0, 1, 1, 0);
    // zeros (R5)
    drive("R5 plus zero",         80'h0,                     2'b00, 2'b10, 0, 64'd0, 0, 0, 0, 0);
    drive("R5 minus zero",        80'h8000_0000000000000000, 2'b10, 2'b01, 0, 64'd0, 0, 0, 0, 0);
    // exact value, inexact clear (R10)
    drive("R10 exact 100",        x80(100.0), 2'b00, 2'b00, 0, 64'd100, 0, 0, 0, 0);
    // range after rounding (R7)
    drive("R7 -32768.4 fits",     x80(-32768.4), 2'b00, 2'b00, 1, IND16, 0, 1, 0, 0);
    drive("R7 32767.4 zero",      x80(32767.4),  2'b00, 2'b11, 1, 64'd32767, 0, 1, 0, 0);
    drive("R9 32767.6 masked",    x80(32767.6),  2'b00, 2'b00, 1, IND16, 1, 0, 0, 0);
    drive("R8 32767.6 unmasked",  x80(32767.6),  2'b00, 2'b00, 0, 64'd0, 1, 0, 0, 1);
    drive("R7 -2^63 w64",         x80(-9223372036854775808.0), 2'b10, 2'b00, 0, IND64, 0, 0, 0, 0);
    drive("R9 +2^63 w64",         x80(9223372036854775808.0),  2'b10, 2'b00, 1, IND64, 1, 0, 0, 0);
    drive("R9 2^70 w64",          x80(1180591620717411303424.0), 2'b10, 2'b00, 1, IND64, 1, 0, 0, 0);
    // width select (R2)
    drive("R2 2^40 w11",          x80(1099511627776.0), 2'b11, 2'b00, 1, 64'h0000_0100_0000_0000, 0, 0, 0, 0);
    drive("R2 2^40 w32",          x80(1099511627776.0), 2'b01, 2'b00, 1, IND32, 1, 0, 0, 0);
    // special classes (R6)
    drive("R6 inf masked w32",    80'h7FFF_8000000000000000, 2'b01, 2'b00, 1, IND32, 1, 0, 0, 0);
    drive("R6 qnan unmasked",     80'h7FFF_C000000000000000, 2'b10, 2'b00, 0, 64'd0, 1, 0, 0, 1);
    drive("R6 unsupported",       80'h4000_4000000000000000, 2'b00, 2'b00, 1, IND16, 1, 0, 0, 0);
    // denormal (R12)
    drive("R12 denormal up",      80'h0000_0000000000000001, 2'b01, 2'b10, 1, 64'd1, 0, 1, 1, 0);
    drive("R12 denormal near",    80'h8000_0000000000000001, 2'b01, 2'b00, 1, 64'd0, 0, 1, 0, 0);

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 idle out_valid", 64'(out_valid), 64'd0);
    check("R1 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule